// File: doc/BRIEF.md
# Serial EEPROM Station Address Loader

This block reads a small serial EEPROM over a four-wire link: select, shift clock, data toward the memory and data back from it. It fetches 16-bit words with a three-bit read opcode followed by the word address. Once reset is released it loads the device image with no help from software. It first probes word 0 with a six-bit address to learn how wide the memory's address is. It then reads all 64 words and adds them modulo 2^16. The first three words become a 48-bit station address, which is released only when the sum matches a fixed signature. If the sum does not match, the address is forced to zero and an error flag is raised.

After the load, a host can read any single word through a simple request/done port, using the address width found by the probe. A request made while the load is still running waits until the load is over. Every shift-clock half period lasts `HALF_CYCLES` system clocks. This parameter is set so that each half period is at least 1 µs. The default of 125 suits a 125 MHz clock.

The serial engine moves through these states: `SH_IDLE`, `SH_DESEL` (select low), `SH_SELECT` (select high, clock low), then `SH_CMD_LO`/`SH_CMD_HI` once per command bit. It next passes through `SH_GAP` and then `SH_DAT_HI`/`SH_DAT_LO` once per data bit. It finishes in `SH_END` (select low), which raises done on its last cycle and returns to `SH_IDLE`. Every state of the serial engine lasts one half period. The load sequencer goes `SQ_PROBE_GO` → `SQ_PROBE_WAIT`, which latches the width. It then repeats `SQ_LOAD_GO` → `SQ_LOAD_WAIT` once for each word. After the last word it goes to `SQ_JUDGE`, which compares the sum and clears busy, and then to `SQ_READY`. From `SQ_READY` a host request leads to `SQ_HOST_WAIT`, which returns to `SQ_READY` once the word has arrived.

Top module: `eeprom_station_loader`

## Requirements
- R1: Each access shifts out the opcode bits 1,1,0 and then the word address, MSB first, on `rom_mosi`. Each bit is set while `rom_clk` is low and held through the high phase that follows.
- R2: After the command, 16 data bits are taken from `rom_miso`, MSB first. Each bit is sampled at the end of a `rom_clk` high phase, and the clock then returns low.
- R3: `rom_sel` is low for one half period before each access starts and for one half period after its last data bit. It stays low between accesses, so every low gap of `rom_sel` lasts at least two half periods.
- R4: Every high phase of `rom_clk` lasts exactly `HALF_CYCLES` clocks, and no low phase inside an access is shorter than that.
- R5: The first access reads word 0 with a 6-bit address. If it returns 16'hFFFF, every later access uses an 8-bit address; otherwise every later access uses a 6-bit address. The load makes 65 accesses: the probe and then words 0 to 63 in increasing order.
- R6: The 64 loaded words are summed modulo 2^16. `addr_valid` goes to 1 only if the sum equals 16'hBABA.
- R7: On a valid image, `station_addr` = {word2, word1, word0}. Byte k sits in bits 8k+7:8k, so byte 0 is the low byte of word 0 and byte 1 is its high byte.
- R8: On a sum mismatch, `csum_err` = 1, `addr_valid` = 0 and `station_addr` = 0.
- R9: While reset is held and from reset release until the load completes, `busy` = 1 and `addr_valid`, `csum_err` and `station_addr` are all 0. Once `busy` falls, it and the three results stay unchanged until the next reset.
- R10: While `busy` = 0 and no access is running, a high `host_req` reads the word at `host_addr`. In 6-bit mode only the low 6 bits of `host_addr` are used. `host_done` then pulses for one cycle with the word on `host_data`. A request made while `busy` is high does not complete until `busy` has fallen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rom_sel | output | 1 | Serial memory select, active high |
| rom_clk | output | 1 | Serial shift clock |
| rom_mosi | output | 1 | Command and address bits to the memory |
| rom_miso | input | 1 | Data bits from the memory |
| host_req | input | 1 | Single-word read request (level) |
| host_addr | input | 8 | Word address for a host read |
| host_done | output | 1 | One-cycle pulse when `host_data` is valid |
| host_data | output | 16 | Word returned by a host read |
| busy | output | 1 | High until the automatic load has completed |
| station_addr | output | 48 | Loaded station address, byte 0 in bits 7:0 |
| addr_valid | output | 1 | Load complete and signature matched |
| csum_err | output | 1 | Load complete and signature mismatched |

## Verification
A shift counter or command register that is out of step shows up on the serial pins within one access, at most about 60 half periods. It appears as a wrong opcode or address bit, or as the wrong number of clock pulses within a select window. A wrong width decision or a wrong word index shows up in the same way on the very next access after the probe. It also changes the recorded address sequence. A fault in the running sum or in where the station words are kept is only visible when `busy` falls, about 65 accesses after reset, in the form of the wrong flag or the wrong address bytes. A fault in host hand-off shows within one access after the request.

// File: rtl/eesl_pkg.sv
package eesl_pkg;

    localparam int OPCODE_W = 3;
    localparam logic [OPCODE_W-1:0] READ_OPCODE = 3'b110;

    typedef enum logic [3:0] {
        SH_IDLE,
        SH_DESEL,
        SH_SELECT,
        SH_CMD_LO,
        SH_CMD_HI,
        SH_GAP,
        SH_DAT_HI,
        SH_DAT_LO,
        SH_END
    } shift_state_t;

    typedef enum logic [2:0] {
        SQ_PROBE_GO,
        SQ_PROBE_WAIT,
        SQ_LOAD_GO,
        SQ_LOAD_WAIT,
        SQ_JUDGE,
        SQ_READY,
        SQ_HOST_WAIT
    } seq_state_t;

endpackage

// File: rtl/eesl_halfclk.sv
module eesl_halfclk #(
    parameter int HALF_CYCLES = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = $clog2(HALF_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(HALF_CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

    assign tick = run && (cnt == LAST);

endmodule

// File: rtl/eesl_shifter.sv
module eesl_shifter
    import eesl_pkg::*;
#(
    parameter int AW_NARROW = 6,
    parameter int AW_WIDE   = 8,
    parameter int WORD_W    = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               start,
    input  logic               wide,
    input  logic [AW_WIDE-1:0] addr,
    output logic               run,
    output logic               done,
    output logic [WORD_W-1:0]  rdata,
    output logic               rom_sel,
    output logic               rom_clk,
    output logic               rom_mosi,
    input  logic               rom_miso
);
    localparam int CMD_W   = OPCODE_W + AW_WIDE;
    localparam int CNT_MAX = (CMD_W > WORD_W) ? CMD_W : WORD_W;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] NARROW_BITS = CNT_W'(OPCODE_W + AW_NARROW);
    localparam logic [CNT_W-1:0] WIDE_BITS   = CNT_W'(CMD_W);
    localparam logic [CNT_W-1:0] DATA_BITS   = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] ONE         = CNT_W'(1);

    shift_state_t state, nxt;
    logic [CMD_W-1:0]  cmd_sr;
    logic [CNT_W-1:0]  bits_left;
    logic [WORD_W-1:0] data_sr;
    logic [CMD_W-1:0]  cmd_narrow;
    logic [CMD_W-1:0]  cmd_wide;
    logic              last_bit;

    // Narrow addresses are left-aligned so the MSB always leaves first.
    assign cmd_wide   = {READ_OPCODE, addr};
    assign cmd_narrow = {READ_OPCODE, AW_WIDE'(addr[AW_NARROW-1:0]) << (AW_WIDE - AW_NARROW)};
    assign last_bit   = (bits_left == ONE);
    assign rdata      = data_sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SH_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            SH_IDLE:   if (start) nxt = SH_DESEL;
            SH_DESEL:  if (tick) nxt = SH_SELECT;
            SH_SELECT: if (tick) nxt = SH_CMD_LO;
            SH_CMD_LO: if (tick) nxt = SH_CMD_HI;
            SH_CMD_HI: if (tick) nxt = last_bit ? SH_GAP : SH_CMD_LO;
            SH_GAP:    if (tick) nxt = SH_DAT_HI;
            SH_DAT_HI: if (tick) nxt = SH_DAT_LO;
            SH_DAT_LO: if (tick) nxt = last_bit ? SH_END : SH_DAT_HI;
            SH_END:    if (tick) nxt = SH_IDLE;
            default:   nxt = SH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_sr    <= '0;
            bits_left <= '0;
            data_sr   <= '0;
        end else if (state == SH_IDLE) begin
            if (start) begin
                cmd_sr    <= wide ? cmd_wide : cmd_narrow;
                bits_left <= wide ? WIDE_BITS : NARROW_BITS;
            end
        end else if (tick) begin
            case (state)
                SH_CMD_HI: begin
                    cmd_sr    <= cmd_sr << 1;
                    bits_left <= last_bit ? DATA_BITS : bits_left - ONE;
                end
                SH_DAT_HI: data_sr   <= {data_sr[WORD_W-2:0], rom_miso};
                SH_DAT_LO: bits_left <= bits_left - ONE;
                default: ;
            endcase
        end
    end

    always_comb begin
        rom_sel  = 1'b1;
        rom_clk  = 1'b0;
        rom_mosi = 1'b0;
        run      = 1'b1;
        done     = 1'b0;
        unique case (state)
            SH_IDLE: begin
                rom_sel = 1'b0;
                run     = 1'b0;
            end
            SH_DESEL:  rom_sel = 1'b0;
            SH_CMD_LO: rom_mosi = cmd_sr[CMD_W-1];
            SH_CMD_HI: begin
                rom_mosi = cmd_sr[CMD_W-1];
                rom_clk  = 1'b1;
            end
            SH_DAT_HI: rom_clk = 1'b1;
            SH_END: begin
                rom_sel = 1'b0;
                done    = tick;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/eesl_sequencer.sv
module eesl_sequencer
    import eesl_pkg::*;
#(
    parameter int          AW_WIDE   = 8,
    parameter int          WORD_W    = 16,
    parameter int          WORDS     = 64,
    parameter int          STN_WORDS = 3,
    parameter logic [15:0] SIGNATURE = 16'hBABA
) (
    input  logic                        clk,
    input  logic                        rst_n,
    output logic                        sh_start,
    output logic                        sh_wide,
    output logic [AW_WIDE-1:0]          sh_addr,
    input  logic                        sh_done,
    input  logic [WORD_W-1:0]           sh_rdata,
    input  logic                        host_req,
    input  logic [AW_WIDE-1:0]          host_addr,
    output logic                        host_done,
    output logic [WORD_W-1:0]           host_data,
    output logic                        busy,
    output logic [STN_WORDS*WORD_W-1:0] station_addr,
    output logic                        addr_valid,
    output logic                        csum_err
);
    localparam int IDX_W = $clog2(WORDS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

    seq_state_t state, nxt;
    logic                               wide_q;
    logic [IDX_W-1:0]                   idx;
    logic [WORD_W-1:0]                  sum;
    logic [STN_WORDS-1:0][WORD_W-1:0]   stn;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SQ_PROBE_GO;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            SQ_PROBE_GO:   nxt = SQ_PROBE_WAIT;
            SQ_PROBE_WAIT: if (sh_done) nxt = SQ_LOAD_GO;
            SQ_LOAD_GO:    nxt = SQ_LOAD_WAIT;
            SQ_LOAD_WAIT:  if (sh_done) nxt = (idx == LAST_IDX) ? SQ_JUDGE : SQ_LOAD_GO;
            SQ_JUDGE:      nxt = SQ_READY;
            SQ_READY:      if (host_req) nxt = SQ_HOST_WAIT;
            SQ_HOST_WAIT:  if (sh_done) nxt = SQ_READY;
            default:       nxt = SQ_PROBE_GO;
        endcase
    end

    always_comb begin
        sh_start = 1'b0;
        sh_wide  = wide_q;
        sh_addr  = host_addr;
        unique case (state)
            SQ_PROBE_GO: begin
                sh_start = 1'b1;
                sh_wide  = 1'b0;
                sh_addr  = '0;
            end
            SQ_LOAD_GO: begin
                sh_start = 1'b1;
                sh_addr  = AW_WIDE'(idx);
            end
            SQ_READY: sh_start = host_req;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wide_q       <= 1'b0;
            idx          <= '0;
            sum          <= '0;
            stn          <= '0;
            busy         <= 1'b1;
            station_addr <= '0;
            addr_valid   <= 1'b0;
            csum_err     <= 1'b0;
            host_done    <= 1'b0;
            host_data    <= '0;
        end else begin
            host_done <= 1'b0;
            case (state)
                SQ_PROBE_WAIT: if (sh_done) begin
                    wide_q <= &sh_rdata;
                    idx    <= '0;
                    sum    <= '0;
                end
                SQ_LOAD_WAIT: if (sh_done) begin
                    sum <= sum + sh_rdata;
                    for (int k = 0; k < STN_WORDS; k++) begin
                        if (idx == IDX_W'(k)) stn[k] <= sh_rdata;
                    end
                    if (idx != LAST_IDX) idx <= idx + IDX_W'(1);
                end
                SQ_JUDGE: begin
                    busy <= 1'b0;
                    if (sum == SIGNATURE[WORD_W-1:0]) begin
                        addr_valid   <= 1'b1;
                        station_addr <= stn;
                    end else begin
                        csum_err     <= 1'b1;
                        station_addr <= '0;
                    end
                end
                SQ_HOST_WAIT: if (sh_done) begin
                    host_done <= 1'b1;
                    host_data <= sh_rdata;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/eeprom_station_loader.sv
module eeprom_station_loader #(
    parameter int          HALF_CYCLES = 125,
    parameter int          AW_NARROW   = 6,
    parameter int          AW_WIDE     = 8,
    parameter int          WORD_W      = 16,
    parameter int          WORDS       = 64,
    parameter int          STN_WORDS   = 3,
    parameter logic [15:0] SIGNATURE   = 16'hBABA
) (
    input  logic                        clk,
    input  logic                        rst_n,
    output logic                        rom_sel,
    output logic                        rom_clk,
    output logic                        rom_mosi,
    input  logic                        rom_miso,
    input  logic                        host_req,
    input  logic [AW_WIDE-1:0]          host_addr,
    output logic                        host_done,
    output logic [WORD_W-1:0]           host_data,
    output logic                        busy,
    output logic [STN_WORDS*WORD_W-1:0] station_addr,
    output logic                        addr_valid,
    output logic                        csum_err
);
    logic               tick;
    logic               run;
    logic               sh_start;
    logic               sh_wide;
    logic               sh_done;
    logic [AW_WIDE-1:0] sh_addr;
    logic [WORD_W-1:0]  sh_rdata;

    eesl_halfclk #(
        .HALF_CYCLES(HALF_CYCLES)
    ) u_half (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .tick (tick)
    );

    eesl_shifter #(
        .AW_NARROW(AW_NARROW),
        .AW_WIDE  (AW_WIDE),
        .WORD_W   (WORD_W)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .start   (sh_start),
        .wide    (sh_wide),
        .addr    (sh_addr),
        .run     (run),
        .done    (sh_done),
        .rdata   (sh_rdata),
        .rom_sel (rom_sel),
        .rom_clk (rom_clk),
        .rom_mosi(rom_mosi),
        .rom_miso(rom_miso)
    );

    eesl_sequencer #(
        .AW_WIDE  (AW_WIDE),
        .WORD_W   (WORD_W),
        .WORDS    (WORDS),
        .STN_WORDS(STN_WORDS),
        .SIGNATURE(SIGNATURE)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .sh_start    (sh_start),
        .sh_wide     (sh_wide),
        .sh_addr     (sh_addr),
        .sh_done     (sh_done),
        .sh_rdata    (sh_rdata),
        .host_req    (host_req),
        .host_addr   (host_addr),
        .host_done   (host_done),
        .host_data   (host_data),
        .busy        (busy),
        .station_addr(station_addr),
        .addr_valid  (addr_valid),
        .csum_err    (csum_err)
    );

endmodule

// File: rtl/eesl_checker.sv
module eesl_checker #(
    parameter int STN_W = 48
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rom_sel,
    input logic             rom_clk,
    input logic             rom_mosi,
    input logic             busy,
    input logic [STN_W-1:0] station_addr,
    input logic             addr_valid,
    input logic             csum_err,
    input logic             host_done
);
    // R1: the shift clock only pulses inside a select window
    p_clk_inside_sel_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rom_clk |-> rom_sel);

    // R1: the outgoing bit does not move during a high clock phase
    p_mosi_held_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_clk && $past(rom_clk)) |-> $stable(rom_mosi));

    // R3: a dropped select stays low for more than one cycle
    p_sel_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rom_sel) |=> !rom_sel);

    // R9: once the load has finished it never restarts without reset
    p_busy_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> !busy);

    // R9: no result is visible while loading
    p_quiet_while_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!addr_valid && !csum_err && station_addr == '0));

    // R9: results frozen after the load
    p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy)) |-> ($stable(station_addr) && $stable(addr_valid) && $stable(csum_err)));

    // R8: a mismatch hides the address and excludes the valid flag
    p_err_zeroes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        csum_err |-> (!addr_valid && station_addr == '0));

    // R10: host words only arrive after the load, with the link idle
    p_host_after_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        host_done |-> (!busy && !rom_sel));

    // R10: done is a single-cycle pulse
    p_host_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        host_done |=> !host_done);

endmodule

bind eeprom_station_loader eesl_checker #(
    .STN_W(STN_WORDS * WORD_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rom_sel     (rom_sel),
    .rom_clk     (rom_clk),
    .rom_mosi    (rom_mosi),
    .busy        (busy),
    .station_addr(station_addr),
    .addr_valid  (addr_valid),
    .csum_err    (csum_err),
    .host_done   (host_done)
);

// File: tb/sim_eeprom_station_loader.sv
module sim_eeprom_station_loader;
    localparam int HALF = 3;
    localparam logic [15:0] SIG = 16'hBABA;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rom_sel, rom_clk, rom_mosi, rom_miso;
    logic        host_req = 1'b0;
    logic [7:0]  host_addr = 8'h00;
    logic        host_done;
    logic [15:0] host_data;
    logic        busy;
    logic [47:0] station_addr;
    logic        addr_valid, csum_err;

    int n_checks = 0;
    int n_errors = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    eeprom_station_loader #(.HALF_CYCLES(HALF)) u0 (
        .clk(clk), .rst_n(rst_n),
        .rom_sel(rom_sel), .rom_clk(rom_clk), .rom_mosi(rom_mosi), .rom_miso(rom_miso),
        .host_req(host_req), .host_addr(host_addr), .host_done(host_done), .host_data(host_data),
        .busy(busy), .station_addr(station_addr), .addr_valid(addr_valid), .csum_err(csum_err)
    );

    // ---------------- serial memory model ----------------
    logic [15:0] mem [256];
    int          dev_aw = 6;
    int          edge_n = 0;
    logic [10:0] in_sr = '0;
    logic        miso_q = 1'b1;
    int          acc_cnt = 0;
    logic [2:0]  acc_cmd [1024];
    logic [7:0]  acc_addr [1024];

    assign rom_miso = miso_q;

    always @(posedge rom_clk or negedge rom_sel) begin
        if (!rom_sel) begin
            acc_cmd[acc_cnt % 1024]  = 3'(in_sr >> dev_aw);
            acc_addr[acc_cnt % 1024] = 8'(int'(in_sr) & ((1 << dev_aw) - 1));
            acc_cnt = acc_cnt + 1;
            edge_n  = 0;
            miso_q  = 1'b1;
        end else begin
            edge_n = edge_n + 1;
            if (edge_n <= 3 + dev_aw) begin
                in_sr = {in_sr[9:0], rom_mosi};
            end else if (edge_n <= 19 + dev_aw) begin
                miso_q = mem[int'(in_sr) & ((1 << dev_aw) - 1)][15 - (edge_n - 4 - dev_aw)];
            end else begin
                miso_q = 1'b1;
            end
        end
    end

    // ---------------- pin timing monitors (R3, R4) ----------------
    int hi_run = 0, lo_run = 0, sel_lo = 0;
    int hi_bad = 0, hi_seen = 0, lo_bad = 0, gap_bad = 0;

    always @(negedge clk) begin
        if (rom_clk) begin
            hi_run = hi_run + 1;
            if (lo_run > 0 && lo_run < HALF) lo_bad = lo_bad + 1;
            lo_run = 0;
        end else begin
            if (hi_run > 0) begin
                hi_seen = hi_seen + 1;
                if (hi_run != HALF) hi_bad = hi_bad + 1;
            end
            hi_run = 0;
            if (rom_sel) lo_run = lo_run + 1; else lo_run = 0;
        end
        if (!rom_sel) begin
            sel_lo = sel_lo + 1;
        end else begin
            if (sel_lo > 0 && sel_lo < 2 * HALF) gap_bad = gap_bad + 1;
            sel_lo = 0;
        end
    end

    // ---------------- checks and helpers ----------------
    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] image_sum();
        logic [15:0] s = '0;
        for (int k = 0; k < 64; k++) s = s + mem[k];
        return s;
    endfunction

    task automatic build_image(input int aw, input bit good, input int w0_mode);
        for (int k = 0; k < 256; k++) mem[k] = 16'($urandom);
        if (aw == 8) mem[0] = 16'hFFFF;
        else if (w0_mode == 1) mem[0] = 16'hFFFE;
        else if (mem[0] == 16'hFFFF) mem[0] = 16'h1234;
        mem[63] = 16'h0000;
        mem[63] = SIG - image_sum();
        if (!good) mem[63] = mem[63] ^ (16'h0001 << ($urandom % 16));
    endtask

    task automatic host_read(input logic [7:0] a, input int aw, input string req);
        int t = 0;
        logic [15:0] exp;
        exp = mem[int'(a) & ((1 << aw) - 1)];
        @(negedge clk);
        host_req  = 1'b1;
        host_addr = a;
        while (!host_done && t < 5000) begin
            @(negedge clk);
            t++;
        end
        host_req = 1'b0;
        check(host_done === 1'b1, {req, " host_done"}, 64'(host_done), 64'd1);
        check(host_data === exp, {req, " host word"}, 64'(host_data), 64'(exp));
    endtask

    task automatic run_load(input int aw, input bit good, input int w0_mode,
                            input bit stall, input logic [7:0] stall_addr);
        int t = 0;
        int base;
        int early = 0;
        int seq_bad = 0;
        logic [15:0] s;
        logic exp_ok;
        logic [47:0] exp_stn;
        build_image(aw, good, w0_mode);
        dev_aw = aw;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R9: reset state
        check(busy === 1'b1 && addr_valid === 1'b0 && csum_err === 1'b0 && station_addr === '0,
              "R9 reset state", {busy, addr_valid, csum_err, station_addr}, {3'b100, 48'h0});
        base = acc_cnt;
        if (stall) begin
            host_req  = 1'b1;
            host_addr = stall_addr;
        end
        rst_n = 1'b1;
        while (busy && t < 40000) begin
            @(negedge clk);
            if (host_done) early++;
            t++;
        end
        s = image_sum();
        exp_ok  = (s == SIG);
        exp_stn = exp_ok ? {mem[2], mem[1], mem[0]} : 48'h0;
        check(busy === 1'b0, "R9 busy falls", 64'(busy), 64'd0);
        check(acc_cnt - base == 65, "R5 access count", 64'(acc_cnt - base), 64'd65);
        for (int k = 0; k < 65; k++) begin
            if (acc_cmd[(base + k) % 1024] !== 3'b110) seq_bad++;
            if (acc_addr[(base + k) % 1024] !== 8'((k == 0) ? 0 : k - 1)) seq_bad++;
        end
        check(seq_bad == 0, "R1/R5 opcode and address order", 64'(seq_bad), 64'd0);
        check(addr_valid === exp_ok, "R6 valid flag", 64'(addr_valid), 64'(exp_ok));
        check(csum_err === !exp_ok, "R8 error flag", 64'(csum_err), 64'(!exp_ok));
        check(station_addr === exp_stn, exp_ok ? "R7 station bytes" : "R8 zeroed station",
              64'(station_addr), 64'(exp_stn));
        if (stall) begin
            check(early == 0, "R10 stalled while busy", 64'(early), 64'd0);
            host_read(stall_addr, aw, "R10 stalled request");
        end
    endtask

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            n_errors++;
            $display("FAIL watchdog actual=%0d expected=<190000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    // ---------------- main sequence ----------------
    initial begin
        void'($urandom(32'd20250611));
        for (int k = 0; k < 256; k++) mem[k] = 16'h0;

        // narrow device, good image, request held from reset
        run_load(6, 1'b1, 0, 1'b1, 8'h07);
        for (int k = 0; k < 3; k++) host_read(8'($urandom % 64), 6, "R10 narrow read");
        host_read(8'h85, 6, "R10 narrow truncation");      // low 6 bits -> word 5
        host_read(8'h3F, 6, "R2 last word");

        // narrow device, corrupted sum
        run_load(6, 1'b0, 0, 1'b0, 8'h00);
        // word 0 = FFFE keeps the 6-bit width
        run_load(6, 1'b1, 1, 1'b0, 8'h00);

        // wide device: probe reads all ones
        run_load(8, 1'b1, 0, 1'b1, 8'hC5);
        host_read(8'hF0, 8, "R5 wide read");
        host_read(8'($urandom), 8, "R10 wide read");
        run_load(8, 1'b0, 0, 1'b0, 8'h00);

        // random mix
        for (int r = 0; r < 2; r++) begin
            run_load((($urandom % 2) == 0) ? 6 : 8, 1'($urandom % 2), 0, 1'b0, 8'h00);
        end

        check(hi_seen > 0 && hi_bad == 0, "R4 clock high width", 64'(hi_bad), 64'd0);
        check(lo_bad == 0, "R4 clock low width", 64'(lo_bad), 64'd0);
        check(gap_bad == 0, "R3 select gap", 64'(gap_bad), 64'd0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule